// File: doc/BRIEF.md
# Dual-Bus Register Bank

A bank of general-purpose registers shared between two data buses, A and B. Each bus has its own port with a register-number input, an active-low load strobe and an active-low drive strobe. A port either captures the value on its bus into the selected register, or presents the selected register on its bus. The two ports work independently, so in one cycle port A can load or drive one register while port B loads or drives another. The datapath that surrounds the bank (arithmetic unit, bus arbitration, control sequencer) lives outside it.

Each bus is modelled as a separate incoming value (`*_bus_in`) and an outgoing value with an output enable (`*_bus_out`, `*_bus_oe`). The enclosing chip merges these into the shared bus. A load is committed when its strobe is released: the bank remembers the bus value and register number from the last cycle the strobe was held low, and writes them on the clock edge at which it first samples the strobe high. This lets the bus settle fully before capture, and lets another source (for example an arithmetic unit) drive a bus while the port on that bus loads from it.

Top module: `dual_bus_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to 0x0000 and leaves no load pending, so after reset every register reads 0x0000 on both ports.
- R2: While a port's drive strobe is low, its output enable is 1 and its output equals the register selected by its register number, in the same cycle, with no clock delay.
- R3: While a port's drive strobe is high, its output enable is 0 and its output value is 0x0000.
- R4: A load writes the bus value and register number sampled in the last cycle its strobe was low. The write happens on the clock edge that first samples the strobe high again. Bus values seen earlier in a longer strobe, or seen after its release, are not written.
- R5: While a load strobe is still low, and in the cycle in which it is released, the target register keeps its old value as seen on either port.
- R6: Both ports can load different registers in the same release cycle, and both writes take effect.
- R7: If both ports commit a load to the same register on the same edge, the value from port B is kept.
- R8: A port may drive and load in the same cycle. Its output shows the register's previous value until the commit edge and the new value afterwards.
- R9: A register that no port writes keeps its value indefinitely, whatever the other port does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_sel | input | 4 | Register number for port A |
| a_load_n | input | 1 | Port A load strobe, active low |
| a_drive_n | input | 1 | Port A drive strobe, active low |
| a_bus_in | input | 16 | Value currently present on bus A |
| a_bus_out | output | 16 | Value port A places on bus A |
| a_bus_oe | output | 1 | Port A drives bus A when 1 |
| b_sel | input | 4 | Register number for port B |
| b_load_n | input | 1 | Port B load strobe, active low |
| b_drive_n | input | 1 | Port B drive strobe, active low |
| b_bus_in | input | 16 | Value currently present on bus B |
| b_bus_out | output | 16 | Value port B places on bus B |
| b_bus_oe | output | 1 | Port B drives bus B when 1 |

## Verification
Drive results are due in the same cycle as the strobe and register number, because the read path is purely combinational. A load becomes visible one cycle after the release cycle: it is committed on the edge that closes the cycle in which the strobe goes high. The driver applies each cycle's inputs just after a rising edge and queues the expected outputs for that cycle alone. The monitor compares them at the following falling edge. So each expectation lands exactly in its due cycle, and a load committed one cycle early or late shows up as a mismatch in the hold, release or readback cycle.

// File: rtl/drbf_pkg.sv
package drbf_pkg;
    localparam int NUM_PORTS = 2;

    // Port index order also fixes write priority: higher index wins.
    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } port_e;
endpackage

// File: rtl/drbf_capture.sv
module drbf_capture #(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] bus_in,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        logic              strobe_n;
        logic [SEL_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d          = cap_q;
        cap_d.strobe_n = load_n;
        if (!load_n) begin
            cap_d.addr = sel;
            cap_d.data = bus_in;
        end
        if (rst) begin
            cap_d = '{strobe_n: 1'b1, addr: '0, data: '0};
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    // Commit on the first sampled high level after a low one.
    assign wr_en   = !cap_q.strobe_n && load_n && !rst;
    assign wr_addr = cap_q.addr;
    assign wr_data = cap_q.data;

    // R4: committed data is the bus value of the last low-strobe cycle
    assert_commit_last_sample_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_data == $past(bus_in) && wr_addr == $past(sel)));
endmodule

// File: rtl/drbf_bank.sv
module drbf_bank #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 16,
    parameter int SEL_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_a,
    input  logic [SEL_W-1:0]             addr_a,
    input  logic [DATA_W-1:0]            data_a,
    input  logic                         wr_b,
    input  logic [SEL_W-1:0]             addr_b,
    input  logic [DATA_W-1:0]            data_b,
    output logic [NREGS-1:0][DATA_W-1:0] regs
);
    logic [NREGS-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_a) regs_d[addr_a] = data_a;
        // Port B applied last so it overrides port A on a shared target.
        if (wr_b) regs_d[addr_b] = data_b;
        if (rst)  regs_d = '0;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R1: reset clears the whole bank
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (regs_q == '0));

    // R7: port B keeps the register on a collision
    assert_b_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_a && wr_b && addr_a == addr_b) |=> (regs_q[$past(addr_b)] == $past(data_b)));

    // R9: without a write the bank does not change
    assert_idle_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_a && !wr_b) |=> $stable(regs_q));
endmodule

// File: rtl/drbf_drive.sv
module drbf_drive #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 16,
    parameter int SEL_W  = 4
) (
    input  logic [NREGS-1:0][DATA_W-1:0] regs,
    input  logic [SEL_W-1:0]             sel,
    input  logic                         drive_n,
    output logic [DATA_W-1:0]            bus_out,
    output logic                         bus_oe
);
    always_comb begin
        bus_oe  = !drive_n;
        bus_out = '0;
        if (!drive_n) bus_out = regs[sel];
    end
endmodule

// File: rtl/dual_bus_regfile.sv
module dual_bus_regfile #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 16,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  a_sel,
    input  logic              a_load_n,
    input  logic              a_drive_n,
    input  logic [DATA_W-1:0] a_bus_in,
    output logic [DATA_W-1:0] a_bus_out,
    output logic              a_bus_oe,
    input  logic [SEL_W-1:0]  b_sel,
    input  logic              b_load_n,
    input  logic              b_drive_n,
    input  logic [DATA_W-1:0] b_bus_in,
    output logic [DATA_W-1:0] b_bus_out,
    output logic              b_bus_oe
);
    import drbf_pkg::*;

    logic [NUM_PORTS-1:0][SEL_W-1:0]  p_sel;
    logic [NUM_PORTS-1:0]             p_load_n;
    logic [NUM_PORTS-1:0]             p_drive_n;
    logic [NUM_PORTS-1:0][DATA_W-1:0] p_bus_in;
    logic [NUM_PORTS-1:0][DATA_W-1:0] p_bus_out;
    logic [NUM_PORTS-1:0]             p_bus_oe;
    logic [NUM_PORTS-1:0]             p_wr;
    logic [NUM_PORTS-1:0][SEL_W-1:0]  p_wr_addr;
    logic [NUM_PORTS-1:0][DATA_W-1:0] p_wr_data;
    logic [NREGS-1:0][DATA_W-1:0]     regs;

    assign p_sel[PORT_A]     = a_sel;
    assign p_sel[PORT_B]     = b_sel;
    assign p_load_n[PORT_A]  = a_load_n;
    assign p_load_n[PORT_B]  = b_load_n;
    assign p_drive_n[PORT_A] = a_drive_n;
    assign p_drive_n[PORT_B] = b_drive_n;
    assign p_bus_in[PORT_A]  = a_bus_in;
    assign p_bus_in[PORT_B]  = b_bus_in;
    assign a_bus_out         = p_bus_out[PORT_A];
    assign b_bus_out         = p_bus_out[PORT_B];
    assign a_bus_oe          = p_bus_oe[PORT_A];
    assign b_bus_oe          = p_bus_oe[PORT_B];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        drbf_capture #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_cap (
            .clk     (clk),
            .rst     (rst),
            .load_n  (p_load_n[p]),
            .sel     (p_sel[p]),
            .bus_in  (p_bus_in[p]),
            .wr_en   (p_wr[p]),
            .wr_addr (p_wr_addr[p]),
            .wr_data (p_wr_data[p])
        );

        drbf_drive #(.DATA_W(DATA_W), .NREGS(NREGS), .SEL_W(SEL_W)) u_drv (
            .regs    (regs),
            .sel     (p_sel[p]),
            .drive_n (p_drive_n[p]),
            .bus_out (p_bus_out[p]),
            .bus_oe  (p_bus_oe[p])
        );

        // R2: a held drive of an unchanged register stays stable
        assert_drive_stable_R2: assert property (@(posedge clk) disable iff (rst)
            (!p_drive_n[p] && $past(!p_drive_n[p]) && $stable(p_sel[p])
             && $past(!rst) && !$past(|p_wr)) |-> $stable(p_bus_out[p]));
    end

    drbf_bank #(.DATA_W(DATA_W), .NREGS(NREGS), .SEL_W(SEL_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_a   (p_wr[PORT_A]),
        .addr_a (p_wr_addr[PORT_A]),
        .data_a (p_wr_data[PORT_A]),
        .wr_b   (p_wr[PORT_B]),
        .addr_b (p_wr_addr[PORT_B]),
        .data_b (p_wr_data[PORT_B]),
        .regs   (regs)
    );
endmodule

// File: tb/dual_bus_regfile_tb.sv
module dual_bus_regfile_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  a_sel, b_sel;
    logic        a_load_n, a_drive_n, b_load_n, b_drive_n;
    logic [15:0] a_bus_in, b_bus_in;
    logic [15:0] a_bus_out, b_bus_out;
    logic        a_bus_oe, b_bus_oe;

    typedef struct {
        int          port;
        logic [15:0] val;
        logic        oe;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_checks = 0;
    int          n_errors = 0;
    logic [15:0] mdl [16];
    bit          done = 0;

    always #2 clk = ~clk;

    dual_bus_regfile u_dut (
        .clk(clk), .rst(rst),
        .a_sel(a_sel), .a_load_n(a_load_n), .a_drive_n(a_drive_n),
        .a_bus_in(a_bus_in), .a_bus_out(a_bus_out), .a_bus_oe(a_bus_oe),
        .b_sel(b_sel), .b_load_n(b_load_n), .b_drive_n(b_drive_n),
        .b_bus_in(b_bus_in), .b_bus_out(b_bus_out), .b_bus_oe(b_bus_oe)
    );

    task automatic go();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        a_load_n = 1; a_drive_n = 1; b_load_n = 1; b_drive_n = 1;
    endtask

    task automatic expect_out(int port, logic [15:0] v, logic oe, string tag);
        item_t it;
        it.port = port; it.val = v; it.oe = oe; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares every item queued for the current cycle.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] ov;
                logic oo;
                it = sb.pop_front();
                ov = (it.port == 0) ? a_bus_out : b_bus_out;
                oo = (it.port == 0) ? a_bus_oe : b_bus_oe;
                n_checks++;
                if (ov !== it.val || oo !== it.oe) begin
                    n_errors++;
                    $display("FAIL %s port %0d: out=%h oe=%b expected out=%h oe=%b",
                             it.tag, it.port, ov, oo, it.val, it.oe);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1; idle();
        a_sel = 0; b_sel = 0; a_bus_in = 0; b_bus_in = 0;
        go(); go();
        rst = 0;
        foreach (mdl[k]) mdl[k] = 16'h0000;

        // R3: no drive means no enable and a zero value
        expect_out(0, 16'h0000, 1'b0, "R3");
        expect_out(1, 16'h0000, 1'b0, "R3");
        go();

        // R1: every register reads zero after reset
        for (int i = 0; i < 16; i++) begin
            a_sel = 4'(i); a_drive_n = 0;
            b_sel = 4'(15 - i); b_drive_n = 0;
            expect_out(0, 16'h0000, 1'b1, "R1");
            expect_out(1, 16'h0000, 1'b1, "R1");
            go();
        end

        // R6: parallel loads of register i on A and 15-i on B
        for (int i = 0; i < 8; i++) begin
            idle();
            a_sel = 4'(i);      a_load_n = 0; a_bus_in = 16'h5555 ^ 16'(i * 16'h0101);
            b_sel = 4'(15 - i); b_load_n = 0; b_bus_in = 16'hAAAA + 16'(i * 16'h0111);
            mdl[i] = a_bus_in;
            mdl[15 - i] = b_bus_in;
            go();
            a_load_n = 1; b_load_n = 1;
            a_bus_in = 16'hDEAD; b_bus_in = 16'hDEAD;   // R4: post-release values ignored
            go();
        end
        idle();
        for (int i = 0; i < 16; i++) begin
            a_sel = 4'(15 - i); a_drive_n = 0;
            b_sel = 4'(i);      b_drive_n = 0;
            expect_out(0, mdl[15 - i], 1'b1, "R6");
            expect_out(1, mdl[i], 1'b1, "R2");
            go();
        end

        // R5/R4: long hold with changing bus, watched from port B
        idle();
        a_sel = 3; a_load_n = 0; a_bus_in = 16'h1234;
        b_sel = 3; b_drive_n = 0;
        expect_out(1, mdl[3], 1'b1, "R5");
        expect_out(0, 16'h0000, 1'b0, "R3");
        go();
        a_bus_in = 16'hBEEF;
        expect_out(1, mdl[3], 1'b1, "R5");
        go();
        a_load_n = 1; a_bus_in = 16'h0000;
        expect_out(1, mdl[3], 1'b1, "R5");
        go();
        mdl[3] = 16'hBEEF;
        expect_out(1, 16'hBEEF, 1'b1, "R4");
        go();

        // R7: same register from both ports
        idle();
        a_sel = 5; a_load_n = 0; a_bus_in = 16'h1111;
        b_sel = 5; b_load_n = 0; b_bus_in = 16'h2222;
        go();
        a_load_n = 1; b_load_n = 1;
        go();
        mdl[5] = 16'h2222;
        a_drive_n = 0;
        expect_out(0, 16'h2222, 1'b1, "R7");
        go();

        // R9: port A loads 7 while port B keeps driving 8
        idle();
        a_sel = 7; a_load_n = 0; a_bus_in = 16'hFFFF;
        b_sel = 8; b_drive_n = 0;
        expect_out(1, mdl[8], 1'b1, "R9");
        go();
        a_load_n = 1;
        expect_out(1, mdl[8], 1'b1, "R9");
        go();
        mdl[7] = 16'hFFFF;
        a_drive_n = 0;
        expect_out(0, 16'hFFFF, 1'b1, "R6");
        expect_out(1, mdl[8], 1'b1, "R9");
        go();

        // R8: same port drives and loads register 10
        idle();
        a_sel = 10; a_drive_n = 0; a_load_n = 0; a_bus_in = 16'h0001;
        expect_out(0, mdl[10], 1'b1, "R8");
        go();
        a_load_n = 1;
        expect_out(0, mdl[10], 1'b1, "R8");
        go();
        mdl[10] = 16'h0001;
        expect_out(0, 16'h0001, 1'b1, "R8");
        go();

        // R9: final dump of the whole bank
        idle();
        for (int i = 0; i < 16; i++) begin
            a_sel = 4'(i);      a_drive_n = 0;
            b_sel = 4'(15 - i); b_drive_n = 0;
            expect_out(0, mdl[i], 1'b1, "R9");
            expect_out(1, mdl[15 - i], 1'b1, "R9");
            go();
        end
        idle();
        expect_out(0, 16'h0000, 1'b0, "R3");
        expect_out(1, 16'h0000, 1'b0, "R3");
        go();
        go();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule